// File: doc/BRIEF.md
# Cascaded CAM Match Priority Node

This block is the per-device cascading logic used when several content-addressable memories are stacked vertically behind one shared address bus. Each copy latches the local compare result of its own array and combines it with an active-low match input from the next higher-priority device. It produces an active-low match output for the next lower-priority device, and it decides whether this device may drive the shared page-and-address bus.

A second chain of the same daisy-chain shape carries the full flag. The multiple-match indication leaves each device as an active-low open-drain style output, and the board resolves it as a wired-AND. Tri-state behaviour is abstracted: the block reports a drive enable and the value it would place on the bus. An external resolver, here the testbench, selects among the drivers.

Selection follows the usual rules. A device is selected when either of its two active-low chip selects is low, or when device-select matching is enabled and the device-select value equals its page number. A device that is not selected during a compare throws away any stale match.

Top module: `cam_cascade_node`

## Requirements
- R1: After reset the latched match and multiple-match results are clear. `mf_n` then follows `mi_n`, `mm_n` is high and `bus_en` is low.
- R2: On a clock edge with `cmp_valid` high and the device selected, the block latches `hit_in`, `multi_in` and `hit_addr`.
- R3: `mf_n` is low whenever `mi_n` is low or the latched match is set; otherwise it is high.
- R4: The device drives (`bus_en` high) with `bus_q = {page_id, latched address}` only when its latched match is set, `mi_n` is high and `oe_n` is low. Across a chain, at most one device drives, and it is the highest-priority matching one.
- R5: While `oe_n` is high, `bus_en` is low.
- R6: With `last_cfg` high, `mi_n` high, no latched match and `oe_n` low, the device drives `bus_q` as all ones.
- R7: A compare edge with the device not selected clears its latched match and multiple-match results, so it reports a mismatch.
- R8: The device is selected when `cs_a_n` is low, or `cs_b_n` is low, or `devsel_en_n` is low and `devsel` equals `page_id`.
- R9: `ff_n` is low only when `fi_n` is low and `full_in` is high, so the last device's output reports the whole stack full.
- R10: `mm_n` is low when the latched multiple-match is set, or when the latched match is set while `mi_n` is low.
- R11: Without `cmp_valid` the latched results do not change, whatever `hit_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_valid | input | 1 | Compare strobe; latches the local result |
| cs_a_n | input | 1 | Chip select A, active low |
| cs_b_n | input | 1 | Chip select B, active low |
| devsel_en_n | input | 1 | Enables selection by device-select value, active low |
| devsel | input | PW | Device-select value compared with `page_id` |
| page_id | input | PW | This device's page number |
| last_cfg | input | 1 | Marks this device as lowest priority |
| hit_in | input | 1 | Local array match |
| hit_addr | input | AW | Local address of the highest-priority hit |
| multi_in | input | 1 | Local array found more than one hit |
| full_in | input | 1 | Local array has no free entry |
| mi_n | input | 1 | Match input from the higher-priority device, active low |
| fi_n | input | 1 | Full input from the higher-priority device, active low |
| oe_n | input | 1 | Output enable, active low |
| mf_n | output | 1 | Match output to the lower-priority device, active low |
| ff_n | output | 1 | Full output to the lower-priority device, active low |
| mm_n | output | 1 | Multiple-match, open-drain style, active low |
| bus_en | output | 1 | This device drives the shared bus |
| bus_q | output | PW+AW | Value driven onto the shared bus |

## Verification
The bench chains three copies and goes after these corner cases:
- Two devices matching at once. A design that ignored its match input would put two drivers on the bus and raise no multiple-match.
- A deselected compare that follows a positive one. A design that kept stale results would keep driving an old address.
- The case where nothing matches. A lowest-priority device that ignored `last_cfg` or its match input would either leave the bus floating or fight a real match.
- Selection through the device-select value alone, with both chip selects high.
- Changing `hit_in` with no compare strobe, which exposes a design that latches outside the strobe.

// File: rtl/cam_cascade_node.sv
module cam_cascade_node #(
  parameter int AW = 4,
  parameter int PW = 2,
  localparam int BW = PW + AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_valid,
  input  logic          cs_a_n,
  input  logic          cs_b_n,
  input  logic          devsel_en_n,
  input  logic [PW-1:0] devsel,
  input  logic [PW-1:0] page_id,
  input  logic          last_cfg,
  input  logic          hit_in,
  input  logic [AW-1:0] hit_addr,
  input  logic          multi_in,
  input  logic          full_in,
  input  logic          mi_n,
  input  logic          fi_n,
  input  logic          oe_n,
  output logic          mf_n,
  output logic          ff_n,
  output logic          mm_n,
  output logic          bus_en,
  output logic [BW-1:0] bus_q
);

  logic          sel;
  logic          match_q;
  logic          multi_q;
  logic [AW-1:0] addr_q;
  logic          drive_hit;
  logic          drive_fill;

  assign sel = ~cs_a_n | ~cs_b_n | (~devsel_en_n & (devsel == page_id));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      multi_q <= 1'b0;
      addr_q  <= '0;
    end else if (cmp_valid) begin
      match_q <= sel & hit_in;
      multi_q <= sel & multi_in;
      if (sel) addr_q <= hit_addr;
    end
  end

  assign drive_hit  = match_q & mi_n & ~oe_n;
  assign drive_fill = last_cfg & ~match_q & mi_n & ~oe_n;

  assign bus_en = drive_hit | drive_fill;
  assign bus_q  = drive_hit  ? {page_id, addr_q} :
                  drive_fill ? {BW{1'b1}} : '0;

  assign mf_n = mi_n & ~match_q;
  assign ff_n = fi_n | ~full_in;
  assign mm_n = ~(multi_q | (match_q & ~mi_n));

endmodule

module cam_cascade_node_chk (
  input logic clk,
  input logic rst_n,
  input logic cmp_valid,
  input logic sel,
  input logic match_q,
  input logic mi_n,
  input logic oe_n,
  input logic last_cfg,
  input logic drive_fill,
  input logic mf_n,
  input logic bus_en
);

  AST_HIGHER_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) !mi_n |-> !bus_en); // R4
  AST_OE_QUIET:      assert property (@(posedge clk) disable iff (!rst_n) oe_n |-> !bus_en); // R5
  AST_CHAIN_PASS:    assert property (@(posedge clk) disable iff (!rst_n) !mi_n |-> !mf_n); // R3
  AST_FILL_LAST:     assert property (@(posedge clk) disable iff (!rst_n) drive_fill |-> last_cfg); // R6
  AST_DESEL_CLEAR:   assert property (@(posedge clk) disable iff (!rst_n) (cmp_valid && !sel) |=> !match_q); // R7
  AST_HOLD:          assert property (@(posedge clk) disable iff (!rst_n) !cmp_valid |=> $stable(match_q)); // R11

endmodule

bind cam_cascade_node cam_cascade_node_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .sel(sel), .match_q(match_q),
  .mi_n(mi_n), .oe_n(oe_n), .last_cfg(last_cfg), .drive_fill(drive_fill),
  .mf_n(mf_n), .bus_en(bus_en)
);

// File: tb/cam_cascade_node_tb.sv
module cam_cascade_node_tb;
  localparam int AW = 4;
  localparam int PW = 2;
  localparam int BW = PW + AW;
  localparam int N  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_valid = 1'b0;
  logic oe_n = 1'b1;
  logic devsel_en_n = 1'b1;
  logic [PW-1:0] devsel = '0;
  logic [N-1:0] cs_a_n = '0, cs_b_n = '1, hit = '0, mh = '0, full = '0;
  logic [AW-1:0] addr [N];
  logic [N-1:0] mf, ff, mm, en;
  logic [BW-1:0] q [N];

  int checks = 0, errors = 0;
  int ndrv;
  logic [BW-1:0] busv;
  logic mm_line;

  always #5 clk = ~clk;

  for (genvar i = 0; i < N; i++) begin : g_dev
    cam_cascade_node #(.AW(AW), .PW(PW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid),
      .cs_a_n(cs_a_n[i]), .cs_b_n(cs_b_n[i]),
      .devsel_en_n(devsel_en_n), .devsel(devsel), .page_id(PW'(i)),
      .last_cfg(i == N-1), .hit_in(hit[i]), .hit_addr(addr[i]),
      .multi_in(mh[i]), .full_in(full[i]),
      .mi_n(i == 0 ? 1'b1 : mf[(i == 0) ? 0 : i-1]),
      .fi_n(i == 0 ? 1'b0 : ff[(i == 0) ? 0 : i-1]),
      .oe_n(oe_n), .mf_n(mf[i]), .ff_n(ff[i]), .mm_n(mm[i]),
      .bus_en(en[i]), .bus_q(q[i]));
  end

  always_comb begin
    ndrv = 0;
    busv = '0;
    for (int i = 0; i < N; i++) if (en[i]) begin ndrv++; busv = q[i]; end
    mm_line = &mm;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare(input logic [N-1:0] h, input logic [N-1:0] m);
    @(negedge clk);
    hit = h; mh = m; cmp_valid = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk(mf == 3'b111, "R1 mf chain", mf, 3'b111);
    chk(mm_line == 1'b1, "R1 mm", mm_line, 1);
    chk(en == '0, "R1 no drive", en, 0);
  endtask

  task automatic t_single();
    oe_n = 1'b0; addr[1] = 4'h5;
    compare(3'b010, 3'b000);
    chk(mf == 3'b001, "R3 mf chain single", mf, 3'b001);
    chk(ndrv == 1 && busv == {2'd1, 4'h5}, "R2 R4 bus single", busv, {2'd1, 4'h5});
    chk(mm_line == 1'b1, "R10 no mm single", mm_line, 1);
  endtask

  task automatic t_two();
    addr[0] = 4'hA; addr[2] = 4'h3;
    compare(3'b101, 3'b000);
    chk(ndrv == 1 && busv == {2'd0, 4'hA}, "R4 highest wins", busv, {2'd0, 4'hA});
    chk(mm_line == 1'b0, "R10 chain mm", mm_line, 0);
  endtask

  task automatic t_oe();
    oe_n = 1'b1; #1;
    chk(ndrv == 0, "R5 oe high", ndrv, 0);
    oe_n = 1'b0; #1;
  endtask

  task automatic t_none();
    compare(3'b000, 3'b000);
    chk(ndrv == 1 && en[2] && busv == '1, "R6 all ones", busv, 6'h3F);
    chk(mf == 3'b111, "R3 no match chain", mf, 3'b111);
  endtask

  task automatic t_desel();
    addr[0] = 4'h7;
    compare(3'b001, 3'b000);
    chk(busv == {2'd0, 4'h7}, "R2 dev0 match", busv, {2'd0, 4'h7});
    cs_a_n = 3'b001;
    compare(3'b001, 3'b000);
    chk(busv == '1 && en == 3'b100, "R7 deselected cleared", busv, 6'h3F);
    cs_a_n = '0;
  endtask

  task automatic t_pagesel();
    cs_a_n = '1; cs_b_n = '1; devsel_en_n = 1'b0; devsel = 2'd1; addr[1] = 4'hC;
    compare(3'b111, 3'b000);
    chk(busv == {2'd1, 4'hC} && ndrv == 1, "R8 page select", busv, {2'd1, 4'hC});
    chk(mf == 3'b001, "R7 R8 others cleared", mf, 3'b001);
    cs_a_n = '1; cs_b_n = 3'b110; devsel_en_n = 1'b1; addr[0] = 4'h2;
    compare(3'b001, 3'b000);
    chk(busv == {2'd0, 4'h2}, "R8 cs b select", busv, {2'd0, 4'h2});
    cs_a_n = '0; cs_b_n = '1;
  endtask

  task automatic t_hold();
    @(negedge clk); hit = 3'b110; addr[0] = 4'hF;
    @(negedge clk); @(negedge clk); #1;
    chk(busv == {2'd0, 4'h2} && mf == 3'b000, "R11 held", busv, {2'd0, 4'h2});
  endtask

  task automatic t_full();
    full = 3'b111; #1;
    chk(ff[2] == 1'b0, "R9 all full", ff[2], 0);
    full = 3'b101; #1;
    chk(ff == 3'b110, "R9 gap", ff, 3'b110);
    full = 3'b000; #1;
  endtask

  task automatic t_local_mm();
    compare(3'b010, 3'b010);
    chk(mm_line == 1'b0 && mm[1] == 1'b0, "R10 local mm", mm_line, 0);
    compare(3'b000, 3'b000);
    chk(mm_line == 1'b1, "R10 mm cleared", mm_line, 1);
  endtask

  initial begin
    for (int i = 0; i < N; i++) addr[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_single();
    t_two();
    t_oe();
    t_none();
    t_desel();
    t_pagesel();
    t_hold();
    t_full();
    t_local_mm();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule